// File: doc/BRIEF.md
# Pulse ordering violation monitor

This block watches three single-bit pulse lines, a, b and c, sampled on one clock, and enforces one ordering rule. After an a pulse ends, the next c pulse must be preceded by a b pulse. The falling edge of a opens an observation window. A rising edge of b inside that window satisfies it. The rule is judged only when c rises.

A new a pulse throws away the window in progress, and the next fall of a opens a fresh window with no b recorded. A series of a pulses with no b or c between them is therefore legal. Each judged c edge produces a one-cycle pass or error strobe. Two saturating counters keep the totals. Only edges matter: a line held high for several clocks counts once.

Top module: `pulse_order_mon`

## Requirements
- R1: While rst_ni is low, err_o, pass_o, err_cnt_o and pass_cnt_o are 0, and the window and edge history are cleared. After reset a c rise is not judged until an a pulse has ended.
- R2: An edge is found by comparing an input with its value at the previous rising clock edge. When b rises after a window opened and c then rises on a later clock, pass_o is 1 for exactly the clock after the sample showing the c rise, and pass_cnt_o increases by one on that clock.
- R3: When c rises in an open window in which b has not risen, err_o is 1 for exactly one clock, with the same timing as pass_o, and err_cnt_o increases by one.
- R4: A c rise with no open window gives neither strobe and leaves both counters unchanged. This covers a c rise before any a pulse and a c rise after a previous check closed the window.
- R5: Several a pulses in a row with no b or c between them raise no error. A rise of a discards the current window and any recorded b, so the sequence a, b, a, c is an error.
- R6: If b and c rise on the same clock inside an open window, the result is an error.
- R7: Levels do not count. A b that was already high when the window opened does not satisfy it. A c held high for several clocks is judged once.
- R8: err_o and pass_o are never 1 on the same clock. Each strobe lasts one clock.
- R9: Each counter is CNT_W bits wide (default 16). It saturates at its all-ones value and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 1 | Pulse that opens the window when it falls |
| b_i | input | 1 | Pulse that satisfies the window when it rises |
| c_i | input | 1 | Pulse whose rise is judged |
| err_o | output | 1 | One-clock ordering error strobe |
| pass_o | output | 1 | One-clock ordering pass strobe |
| err_cnt_o | output | CNT_W | Saturating error count |
| pass_cnt_o | output | CNT_W | Saturating pass count |

## Verification
An input change becomes an edge at the next rising clock. The strobe and the counter step for a c rise register on that same clock edge, so they are visible for the following cycle and drop one clock later. The bench changes inputs only on falling clock edges and lets exactly one rising edge pass before it samples, at the next falling edge. It then samples once more to confirm that the strobe has dropped. A second instance with 4-bit counters reaches saturation within the run time.

// File: rtl/pom_pkg.sv
package pom_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_SAT  = 2'd2
  } win_st_e;
endpackage

// File: rtl/pom_edge_hist.sv
module pom_edge_hist #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] prev_o,
  output logic [W-1:0] rise_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= sig_i[i];
    end
    assign prev_o[i] = prev_q;
    assign rise_o[i] = sig_i[i] & ~prev_q;
  end
endmodule

// File: rtl/pom_order_fsm.sv
module pom_order_fsm
  import pom_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_rise_i,
  input  logic a_fall_i,
  input  logic b_rise_i,
  input  logic c_rise_i,
  output logic err_hit_o,
  output logic pass_hit_o,
  output logic err_o,
  output logic pass_o
);
  win_st_e state_q, state_d;
  logic    check;

  // a edges take priority: a window never spans a high a
  assign check      = c_rise_i & ~a_rise_i & ~a_fall_i;
  assign err_hit_o  = check & (state_q == ST_OPEN);
  assign pass_hit_o = check & (state_q == ST_SAT);

  always_comb begin
    state_d = state_q;
    if (a_rise_i)                              state_d = ST_IDLE;
    else if (a_fall_i)                         state_d = ST_OPEN;
    else if (c_rise_i)                         state_d = ST_IDLE;
    else if (b_rise_i && state_q == ST_OPEN)   state_d = ST_SAT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      err_o   <= 1'b0;
      pass_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      err_o   <= err_hit_o;
      pass_o  <= pass_hit_o;
    end
  end

  AST_PASS_FROM_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |-> $past(state_q) == ST_SAT); // R2
  AST_ERR_FROM_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(state_q) == ST_OPEN); // R3
  AST_CHECK_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o || pass_o) |-> state_q == ST_IDLE); // R4
  AST_A_DISCARDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_rise_i |=> state_q == ST_IDLE); // R5
  AST_SAT_VIA_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SAT && $past(state_q) != ST_SAT) |-> $past(state_q) == ST_OPEN); // R2
endmodule

// File: rtl/pom_sat_cnt.sv
module pom_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CNT_HOLD_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == CNT_MAX |=> cnt_q == CNT_MAX); // R9
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)); // R9
endmodule

// File: rtl/pulse_order_mon.sv
module pulse_order_mon #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_i,
  input  logic             b_i,
  input  logic             c_i,
  output logic             err_o,
  output logic             pass_o,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic [CNT_W-1:0] pass_cnt_o
);
  localparam int NSIG = 3;

  logic [NSIG-1:0] prev, rise;
  logic            a_fall, err_hit, pass_hit;

  pom_edge_hist #(.W(NSIG)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({c_i, b_i, a_i}),
    .prev_o (prev),
    .rise_o (rise)
  );

  assign a_fall = ~a_i & prev[0];

  pom_order_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .a_rise_i   (rise[0]),
    .a_fall_i   (a_fall),
    .b_rise_i   (rise[1]),
    .c_rise_i   (rise[2]),
    .err_hit_o  (err_hit),
    .pass_hit_o (pass_hit),
    .err_o      (err_o),
    .pass_o     (pass_o)
  );

  pom_sat_cnt #(.W(CNT_W)) u_err_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (err_hit),
    .cnt_o  (err_cnt_o)
  );

  pom_sat_cnt #(.W(CNT_W)) u_pass_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (pass_hit),
    .cnt_o  (pass_cnt_o)
  );

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_o && pass_o)); // R8
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o); // R8
  AST_ERR_COUNTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && $past(err_cnt_o) != {CNT_W{1'b1}}) |-> err_cnt_o == $past(err_cnt_o) + 1'b1); // R3
  AST_PASS_COUNTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o && $past(pass_cnt_o) != {CNT_W{1'b1}}) |-> pass_cnt_o == $past(pass_cnt_o) + 1'b1); // R2
  AST_NO_C_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(c_i) && !$past(prev[2])); // R7
endmodule

// File: tb/pulse_order_mon_test.sv
`timescale 1ns/1ps
module pulse_order_mon_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic a_i = 1'b0, b_i = 1'b0, c_i = 1'b0;
  logic err_o, pass_o, err_s, pass_s;
  logic [15:0] err_cnt_o, pass_cnt_o;
  logic [3:0]  err_cnt_s, pass_cnt_s;

  int n_chk = 0, n_bad = 0;
  int e_err = 0, e_pass = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pulse_order_mon uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .c_i(c_i),
    .err_o(err_o), .pass_o(pass_o), .err_cnt_o(err_cnt_o), .pass_cnt_o(pass_cnt_o)
  );

  pulse_order_mon #(.CNT_W(4)) uut_sat (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(a_i), .b_i(b_i), .c_i(c_i),
    .err_o(err_s), .pass_o(pass_s), .err_cnt_o(err_cnt_s), .pass_cnt_o(pass_cnt_s)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // set inputs at a falling edge, pass one rising edge, return at next falling edge
  task automatic drive(input logic av, input logic bv, input logic cv);
    a_i = av; b_i = bv; c_i = cv;
    @(negedge clk_i);
  endtask

  task automatic chk_state(input string req, input int ee, input int ep);
    chk({req, " err_o"}, int'(err_o), ee);
    chk({req, " pass_o"}, int'(pass_o), ep);
    chk({req, " err_cnt"}, int'(err_cnt_o), e_err);
    chk({req, " pass_cnt"}, int'(pass_cnt_o), e_pass);
    chk({req, " sat err_cnt"}, int'(err_cnt_s), (e_err > 15) ? 15 : e_err);
    chk({req, " sat pass_cnt"}, int'(pass_cnt_s), (e_pass > 15) ? 15 : e_pass);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; a_i = 0; b_i = 0; c_i = 0;
    @(negedge clk_i);
    e_err = 0; e_pass = 0;
    chk_state("R1 in reset", 0, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic a_pulse(input int len);
    for (int i = 0; i < len; i++) drive(1, 0, 0);
    drive(0, 0, 0);
  endtask

  task automatic b_pulse(input int len);
    for (int i = 0; i < len; i++) drive(0, 1, 0);
    drive(0, 0, 0);
  endtask

  // c pulse with judged outcome: 0 none, 1 err, 2 pass
  task automatic c_pulse(input string req, input int len, input int res);
    if (res == 1) e_err++;
    if (res == 2) e_pass++;
    drive(0, 0, 1);
    chk_state(req, (res == 1) ? 1 : 0, (res == 2) ? 1 : 0);
    for (int i = 1; i < len; i++) begin
      drive(0, 0, 1);
      chk_state({req, " held"}, 0, 0);
    end
    drive(0, 0, 0);
    chk_state({req, " after"}, 0, 0);
  endtask

  task automatic t_no_window();
    c_pulse("R4 c before any a", 2, 0);
  endtask

  task automatic t_pass();
    a_pulse(2); drive(0, 0, 0);
    b_pulse(2); drive(0, 0, 0);
    c_pulse("R2 a b c pass", 2, 2);
    c_pulse("R4 c after check", 1, 0);
  endtask

  task automatic t_err();
    a_pulse(2); drive(0, 0, 0);
    c_pulse("R3 a c error", 2, 1);
  endtask

  task automatic t_multi_a();
    a_pulse(2);
    chk_state("R5 first a", 0, 0);
    a_pulse(1);
    chk_state("R5 second a", 0, 0);
    a_pulse(2);
    chk_state("R5 third a", 0, 0);
    b_pulse(1);
    c_pulse("R5 a a a b c pass", 1, 2);
    a_pulse(1); b_pulse(1); a_pulse(1);
    c_pulse("R5 a b a c discards b", 1, 1);
  endtask

  task automatic t_same_clk();
    a_pulse(1); drive(0, 0, 0);
    drive(0, 1, 1);
    e_err++;
    chk_state("R6 b and c together", 1, 0);
    drive(0, 0, 0);
    chk_state("R6 after", 0, 0);
  endtask

  task automatic t_levels();
    drive(1, 0, 0);
    drive(1, 1, 0);
    drive(0, 1, 0);
    drive(0, 1, 0);
    drive(0, 0, 0);
    c_pulse("R7 b high before window", 1, 1);
    a_pulse(1); b_pulse(3);
    c_pulse("R7 c held judged once", 3, 2);
  endtask

  task automatic t_reset_mid();
    a_pulse(1); b_pulse(1);
    do_reset();
    c_pulse("R1 reset closes window", 1, 0);
  endtask

  task automatic t_saturate();
    for (int k = 0; k < 17; k++) begin
      a_pulse(1);
      c_pulse("R9 saturation run", 1, 1);
    end
    chk("R9 sat err_cnt at max", int'(err_cnt_s), 15);
    chk("R9 wide err_cnt", int'(err_cnt_o), e_err);
  endtask

  initial begin
    @(negedge clk_i);
    do_reset();
    chk_state("R1 after reset", 0, 0);
    t_no_window();
    t_pass();
    t_err();
    t_multi_a();
    t_same_clk();
    t_levels();
    t_reset_mid();
    t_saturate();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule